// File: doc/BRIEF.md
# Codec Serial Control Writer with Initialisation Sequencer

This block sends 16-bit control words to as many as three audio codecs that share one three-wire serial port. The port has a data line, a clock line and an active-low select line for each codec. A host request carries a codec mask, a register index and a data byte. The block packs them into one command word and shifts it out to every codec whose mask bit is set. All the codecs in the mask receive the same word at the same time.

A built-in sequencer can also run the full codec bring-up list of nine register writes for a chosen mask. It can run that list automatically when reset is released, and it can run it again later on request. A divider parameter sets how many system clocks each serial clock phase lasts. The block reports three things: `busy` while work is in progress, a single-cycle `done` when a host write or a whole bring-up list has finished, and a single-cycle `err` when a request is refused.

Top module: `codec_ctl_port`

## Requirements
- R1: Each command word is `{2'b10, 1'b1, index[4:0], data[7:0]}`, which equals 0xA000 plus (index << 8) plus data. It is shifted out most significant bit first, 16 bits per frame.
- R2: Each bit is placed on `ser_data` while `ser_clk` is low. `ser_clk` then rises so that the codec latches the bit, and falls again. Every serial clock phase lasts exactly CLK_DIV system clocks, and `ser_data` does not change while `ser_clk` is high.
- R3: A frame runs in this order:
  - data and clock go low;
  - `ser_cs_n[i]` goes low for each mask bit i that is set;
  - the 16 bits are shifted;
  - the clock returns low;
  - all selects go high;
  - data and clock go high in idle.

  Selects change only while the clock is low. While the block is not busy, every select is high and both data and clock are high.
- R4: A host request whose mask is above 7 or whose index is above 7 gives one `err` pulse. It causes no bus activity and writes nothing.
- R5: The bring-up list writes nine entries in this order, as register index then value: 1←0x00, 2←0x60, 1←0x03, 0←0x07, 3←0x19, 4←0x7F, 5←0x7F, 6←0x7F, 7←0x7F.
- R6: With INIT_ON_RESET set, the bring-up list runs for RESET_MASK as soon as reset is released. `busy` is already high while reset is held.
- R7: A pulse on `init_req` with a valid `init_mask` runs the bring-up list only on the codecs in that mask. Mask 0x07 addresses all codecs and mask (1 << n) addresses codec n alone.
- R8: `busy` rises in the cycle after a request is accepted and stays high until the work completes. `done` is a one-cycle pulse in the same cycle that `busy` falls, given once per host write and once per complete bring-up list.
- R9: Any host or bring-up request that arrives while the block is busy is refused with an `err` pulse. It does not change any codec register.
- R10: A bring-up request with a mask above 7 gives an `err` pulse and does not start the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Single-cycle host write request |
| req_mask | input | MASK_IN_W | Codec mask for the host write |
| req_index | input | 5 | Register index for the host write |
| req_data | input | 8 | Data byte for the host write |
| init_req | input | 1 | Single-cycle request to run the bring-up list |
| init_mask | input | MASK_IN_W | Codec mask for the bring-up list |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| ser_cs_n | output | N_CS | Active-low select line, one per codec |
| busy | output | 1 | High while a write or the bring-up list is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused or invalid request |

## Verification
The hardest situation to reach is a request that lands in the middle of a running bring-up list. From the outside the list looks like a string of separate frames, so refusing the request has to be shown to leave every register untouched. To get there, the bench first fills one codec with known non-default values. It then starts a single-codec bring-up and issues a host write a few cycles later. At the end it checks that the write was flagged and that the non-targeted codecs kept their values. Three bench shift-register codec models capture each frame only while their own select is low. A sweep of every valid mask and index pair then confirms the word packing and the multi-hot selects.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

   localparam int WORD_W     = 16;
   localparam int IDX_W      = 5;
   localparam int DATA_W     = 8;
   localparam int SCRIPT_LEN = 9;
   localparam int STEP_W     = $clog2(SCRIPT_LEN);

   typedef enum logic [2:0] {
      E_IDLE, E_PRE, E_SEL, E_LOW, E_HIGH, E_TAIL, E_DESEL
   } eng_state_t;

   typedef enum logic [1:0] {
      Q_IDLE, Q_LAUNCH, Q_WAIT
   } seq_state_t;

   // Fixed prefix: chip address 2'b10 and write flag 1'b1.
   function automatic logic [WORD_W-1:0] pack_word(input logic [IDX_W-1:0] idx,
                                                   input logic [DATA_W-1:0] dat);
      return {2'b10, 1'b1, idx, dat};
   endfunction

   // Bring-up list: register index and value for each step.
   function automatic logic [IDX_W+DATA_W-1:0] script_entry(input logic [STEP_W-1:0] step);
      case (step)
         4'd0:    return {5'd1, 8'h00};
         4'd1:    return {5'd2, 8'h60};
         4'd2:    return {5'd1, 8'h03};
         4'd3:    return {5'd0, 8'h07};
         4'd4:    return {5'd3, 8'h19};
         4'd5:    return {5'd4, 8'h7F};
         4'd6:    return {5'd5, 8'h7F};
         4'd7:    return {5'd6, 8'h7F};
         default: return {5'd7, 8'h7F};
      endcase
   endfunction

endpackage

// File: rtl/codec_ctl_shifter.sv
module codec_ctl_shifter
   import codec_ctl_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int N_CS    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   input  logic [N_CS-1:0]   sel_mask,
   output logic              ser_data,
   output logic              ser_clk,
   output logic [N_CS-1:0]   ser_cs_n,
   output logic              fin
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BW = $clog2(WORD_W);

   eng_state_t        st;
   logic [WORD_W-1:0] sh;
   logic [BW-1:0]     bitn;
   logic [N_CS-1:0]   sel;
   logic              dreg;
   logic              phase_end;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign phase_end = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   cnt <= '0;
            else if (st == E_IDLE || cnt == CW'(CLK_DIV-1)) cnt <= '0;
            else                                          cnt <= cnt + 1'b1;
         end
         assign phase_end = (cnt == CW'(CLK_DIV-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= E_IDLE;
         sh   <= '0;
         bitn <= '0;
         sel  <= '0;
         dreg <= 1'b0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (st == E_IDLE) begin
            if (start) begin
               sh   <= word;
               sel  <= sel_mask;
               dreg <= 1'b0;
               bitn <= '0;
               st   <= E_PRE;
            end
         end else if (phase_end) begin
            case (st)
               E_PRE:  st <= E_SEL;
               E_SEL:  begin dreg <= sh[WORD_W-1]; st <= E_LOW; end
               E_LOW:  st <= E_HIGH;
               E_HIGH: begin
                  sh <= sh << 1;
                  if (bitn == BW'(WORD_W-1)) st <= E_TAIL;
                  else begin
                     bitn <= bitn + 1'b1;
                     dreg <= sh[WORD_W-2];
                     st   <= E_LOW;
                  end
               end
               E_TAIL:  st <= E_DESEL;
               default: begin st <= E_IDLE; fin <= 1'b1; end
            endcase
         end
      end
   end

   assign ser_clk  = (st == E_IDLE) || (st == E_HIGH);
   assign ser_data = (st == E_IDLE) ? 1'b1 : dreg;
   assign ser_cs_n = (st == E_SEL || st == E_LOW || st == E_HIGH || st == E_TAIL)
                     ? ~sel : '1;
endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port
   import codec_ctl_pkg::*;
#(
   parameter int          CLK_DIV       = 4,
   parameter int          N_CS          = 3,
   parameter int          MASK_IN_W     = 8,
   parameter bit          INIT_ON_RESET = 1'b1,
   parameter logic [2:0]  RESET_MASK    = 3'b111
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [MASK_IN_W-1:0] req_mask,
   input  logic [4:0]           req_index,
   input  logic [7:0]           req_data,
   input  logic                 init_req,
   input  logic [MASK_IN_W-1:0] init_mask,
   output logic                 ser_data,
   output logic                 ser_clk,
   output logic [N_CS-1:0]      ser_cs_n,
   output logic                 busy,
   output logic                 done,
   output logic                 err
);
   localparam int VALID_IDX = 8;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SCRIPT_LEN-1);

   generate
      if (CLK_DIV < 1)               begin : g_bad_div  $error("CLK_DIV must be at least 1"); end
      if (N_CS < 1 || N_CS > 3)      begin : g_bad_ncs  $error("N_CS must be 1 to 3"); end
      if (MASK_IN_W < N_CS)          begin : g_bad_mw   $error("MASK_IN_W below N_CS"); end
   endgenerate

   function automatic logic mask_ok(input logic [MASK_IN_W-1:0] m);
      return (m >> N_CS) == '0;
   endfunction

   seq_state_t          st;
   logic                in_script;
   logic [STEP_W-1:0]   step;
   logic [N_CS-1:0]     tgt;
   logic [IDX_W-1:0]    h_idx;
   logic [DATA_W-1:0]   h_data;
   logic [WORD_W-1:0]   cur_word;
   logic                eng_start;
   logic                eng_fin;
   logic [IDX_W+DATA_W-1:0] entry;

   assign entry     = script_entry(step);
   assign cur_word  = in_script ? pack_word(entry[IDX_W+DATA_W-1:DATA_W], entry[DATA_W-1:0])
                                : pack_word(h_idx, h_data);
   assign eng_start = (st == Q_LAUNCH);
   assign busy      = (st != Q_IDLE);

   // A bring-up request wins over a host write in the same cycle; the write is refused.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= INIT_ON_RESET ? Q_LAUNCH : Q_IDLE;
         in_script <= INIT_ON_RESET;
         step      <= '0;
         tgt       <= RESET_MASK[N_CS-1:0];
         h_idx     <= '0;
         h_data    <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (st)
            Q_IDLE: begin
               if (init_req) begin
                  if (mask_ok(init_mask)) begin
                     st        <= Q_LAUNCH;
                     in_script <= 1'b1;
                     step      <= '0;
                     tgt       <= init_mask[N_CS-1:0];
                  end else err <= 1'b1;
                  if (req_valid) err <= 1'b1;
               end else if (req_valid) begin
                  if (mask_ok(req_mask) && req_index < 5'(VALID_IDX)) begin
                     st        <= Q_LAUNCH;
                     in_script <= 1'b0;
                     tgt       <= req_mask[N_CS-1:0];
                     h_idx     <= req_index;
                     h_data    <= req_data;
                  end else err <= 1'b1;
               end
            end
            Q_LAUNCH: begin
               if (req_valid || init_req) err <= 1'b1;
               st <= Q_WAIT;
            end
            default: begin
               if (req_valid || init_req) err <= 1'b1;
               if (eng_fin) begin
                  if (in_script && step != LAST_STEP) begin
                     step <= step + 1'b1;
                     st   <= Q_LAUNCH;
                  end else begin
                     st   <= Q_IDLE;
                     done <= 1'b1;
                  end
               end
            end
         endcase
      end
   end

   codec_ctl_shifter #(.CLK_DIV(CLK_DIV), .N_CS(N_CS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eng_start),
      .word     (cur_word),
      .sel_mask (tgt),
      .ser_data (ser_data),
      .ser_clk  (ser_clk),
      .ser_cs_n (ser_cs_n),
      .fin      (eng_fin)
   );
endmodule

// File: rtl/codec_ctl_port_chk.sv
module codec_ctl_port_chk #(
   parameter int N_CS = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ser_data,
   input logic            ser_clk,
   input logic [N_CS-1:0] ser_cs_n,
   input logic            busy,
   input logic            done,
   input logic            err
);
   p_idle_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ser_cs_n == '1 && ser_clk && ser_data));

   p_data_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   p_cs_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_cs_n) |-> !ser_clk);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !busy) |-> ser_cs_n == '1);
endmodule

bind codec_ctl_port codec_ctl_port_chk #(.N_CS(N_CS)) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
   .ser_cs_n(ser_cs_n), .busy(busy), .done(done), .err(err)
);

// File: tb/codec_ctl_port_bench.sv
`timescale 1ns/1ps
module codec_ctl_port_bench;
   localparam int DIV = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_mask = '0;
   logic [4:0] req_index = '0;
   logic [7:0] req_data = '0;
   logic       init_req = 1'b0;
   logic [7:0] init_mask = '0;
   logic       ser_data, ser_clk, busy, done, err;
   logic [2:0] ser_cs_n;

   always #2.5 clk = ~clk;

   codec_ctl_port #(.CLK_DIV(DIV), .N_CS(3), .MASK_IN_W(8),
                    .INIT_ON_RESET(1'b1), .RESET_MASK(3'b111)) u_codec_ctl_port (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
      .req_index(req_index), .req_data(req_data), .init_req(init_req),
      .init_mask(init_mask), .ser_data(ser_data), .ser_clk(ser_clk),
      .ser_cs_n(ser_cs_n), .busy(busy), .done(done), .err(err));

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // Codec models and line monitors, all sampled at the falling system edge.
   logic [15:0] sr    [3];
   int          bitcnt[3];
   int          wcnt  [3];
   logic [15:0] wlog  [3][256];
   logic [7:0]  creg  [3][8];
   logic [7:0]  shadow[3][8];
   int          bad_frames = 0;
   int          hold_viol = 0;
   int          hi_viol = 0;
   int          hi_cnt = 0;
   logic        p_clk = 1'b1, p_data = 1'b1;
   logic [2:0]  p_cs = 3'b111;

   initial begin
      for (int i = 0; i < 3; i++) begin
         sr[i] = '0; bitcnt[i] = 0; wcnt[i] = 0;
         for (int j = 0; j < 8; j++) begin creg[i][j] = '0; shadow[i][j] = '0; end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (ser_clk && p_clk && ser_data !== p_data) hold_viol++;
         if (ser_clk && ser_cs_n != 3'b111) hi_cnt++;
         if (!ser_clk && p_clk) begin
            if (p_cs != 3'b111 && hi_cnt != DIV) hi_viol++;
            hi_cnt = 0;
         end
         for (int i = 0; i < 3; i++) begin
            if (p_cs[i] && !ser_cs_n[i]) bitcnt[i] = 0;
            if (ser_clk && !p_clk && !ser_cs_n[i]) begin
               sr[i] = {sr[i][14:0], ser_data};
               bitcnt[i]++;
            end
            if (!p_cs[i] && ser_cs_n[i]) begin
               if (bitcnt[i] != 16 || sr[i][15:13] != 3'b101 || sr[i][12:11] != 2'b00)
                  bad_frames++;
               else begin
                  creg[i][sr[i][10:8]] = sr[i][7:0];
                  wlog[i][wcnt[i] & 255] = sr[i];
                  wcnt[i]++;
               end
            end
         end
      end
      p_clk = ser_clk; p_data = ser_data; p_cs = ser_cs_n;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] script_word(input int k);
      logic [4:0] ix; logic [7:0] dv;
      case (k)
         0: begin ix = 1; dv = 8'h00; end
         1: begin ix = 2; dv = 8'h60; end
         2: begin ix = 1; dv = 8'h03; end
         3: begin ix = 0; dv = 8'h07; end
         4: begin ix = 3; dv = 8'h19; end
         default: begin ix = 5'(k - 1); dv = 8'h7F; end
      endcase
      return 16'hA000 + (16'(ix) << 8) + 16'(dv);
   endfunction

   task automatic wait_done(input string tag);
      int n = 0;
      while (done !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
      check(done === 1'b1, tag, done, 1);
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R8 done single pulse", {done, busy}, 0);
   endtask

   task automatic host_req(input logic [7:0] m, input logic [4:0] ix, input logic [7:0] d,
                           output logic e, output logic b);
      @(negedge clk);
      req_valid = 1'b1; req_mask = m; req_index = ix; req_data = d;
      @(negedge clk);
      e = err; b = busy;
      req_valid = 1'b0;
   endtask

   task automatic check_script(input logic [2:0] m, input int base[3], input string tag);
      for (int i = 0; i < 3; i++) begin
         if (m[i]) begin
            check(wcnt[i] - base[i] == 9, {tag, " word count"}, wcnt[i] - base[i], 9);
            for (int k = 0; k < 9; k++)
               check(wlog[i][(base[i] + k) & 255] == script_word(k), "R5 script order",
                     wlog[i][(base[i] + k) & 255], script_word(k));
            for (int k = 0; k < 9; k++) shadow[i][script_word(k)[10:8]] = script_word(k)[7:0];
         end else
            check(wcnt[i] == base[i], {tag, " unselected codec quiet"}, wcnt[i], base[i]);
         for (int j = 0; j < 8; j++)
            check(creg[i][j] == shadow[i][j], {tag, " register contents"}, creg[i][j], shadow[i][j]);
      end
   endtask

   task automatic quiet_window(input string tag);
      int tot = wcnt[0] + wcnt[1] + wcnt[2];
      bit ok = 1;
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         if (ser_cs_n !== 3'b111 || ser_clk !== 1'b1 || ser_data !== 1'b1 || busy) ok = 0;
      end
      check(ok && tot == wcnt[0] + wcnt[1] + wcnt[2], tag, ser_cs_n, 3'b111);
   endtask

   initial begin
      logic e, b;
      int base[3];
      repeat (3) @(negedge clk);
      check(ser_cs_n == 3'b111 && ser_clk && ser_data, "R3 idle lines in reset",
            {ser_cs_n, ser_clk, ser_data}, 5'h1F);
      check(busy === 1'b1 && !done && !err, "R6 busy held in reset", {busy, done, err}, 3'b100);
      rst_n = 1'b1;

      // R6/R5: bring-up list for all codecs after reset.
      for (int i = 0; i < 3; i++) base[i] = 0;
      wait_done("R6 reset script completes");
      check_script(3'b111, base, "R6");
      quiet_window("R3 idle after script");

      // R1/R3: every valid mask and index.
      for (int m = 1; m < 8; m++) begin
         for (int ix = 0; ix < 8; ix++) begin
            logic [7:0] d = 8'((m * 37 + ix * 11 + 5) ^ (ix << 5));
            for (int i = 0; i < 3; i++) base[i] = wcnt[i];
            host_req(8'(m), 5'(ix), d, e, b);
            check(!e && b, "R8 busy after accepted write", {e, b}, 2'b01);
            wait_done("R8 host write done");
            for (int i = 0; i < 3; i++) begin
               if (m[i]) begin
                  shadow[i][ix] = d;
                  check(wcnt[i] == base[i] + 1, "R3 selected codec got frame", wcnt[i], base[i] + 1);
                  check(wlog[i][base[i] & 255] == 16'hA000 + (16'(ix) << 8) + 16'(d),
                        "R1 word packing", wlog[i][base[i] & 255], 16'hA000 + (16'(ix) << 8) + 16'(d));
               end else
                  check(wcnt[i] == base[i], "R3 unselected codec quiet", wcnt[i], base[i]);
               check(creg[i][ix] == shadow[i][ix], "R3 codec register", creg[i][ix], shadow[i][ix]);
            end
         end
      end

      // R4: invalid masks and indices.
      foreach (base[i]) base[i] = wcnt[i];
      host_req(8'h08, 5'd0, 8'hEE, e, b);
      check(e && !b, "R4 mask 0x08 rejected", {e, b}, 2'b10);
      quiet_window("R4 no bus activity mask 0x08");
      host_req(8'hFF, 5'd2, 8'hEE, e, b);
      check(e && !b, "R4 mask 0xFF rejected", {e, b}, 2'b10);
      host_req(8'h01, 5'd8, 8'hEE, e, b);
      check(e && !b, "R4 index 8 rejected", {e, b}, 2'b10);
      host_req(8'h07, 5'd31, 8'hEE, e, b);
      check(e && !b, "R4 index 31 rejected", {e, b}, 2'b10);
      quiet_window("R4 no bus activity bad index");
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 8; j++)
            check(creg[i][j] == shadow[i][j], "R4 registers untouched", creg[i][j], shadow[i][j]);

      // R10: bring-up with invalid mask.
      @(negedge clk); init_req = 1'b1; init_mask = 8'h09;
      @(negedge clk); e = err; b = busy; init_req = 1'b0;
      check(e && !b, "R10 bad bring-up mask rejected", {e, b}, 2'b10);
      quiet_window("R10 list not started");

      // R7/R9: codec 1 alone, with a host write arriving mid-list.
      for (int ix = 0; ix < 8; ix++) begin
         host_req(8'h02, 5'(ix), 8'(8'h55 ^ ix), e, b);
         wait_done("R8 preload write done");
         shadow[1][ix] = 8'(8'h55 ^ ix);
      end
      foreach (base[i]) base[i] = wcnt[i];
      @(negedge clk); init_req = 1'b1; init_mask = 8'h02;
      @(negedge clk); init_req = 1'b0;
      check(busy === 1'b1, "R7 busy after bring-up request", busy, 1);
      repeat (40) @(negedge clk);
      host_req(8'h01, 5'd0, 8'hAA, e, b);
      check(e && b, "R9 write refused while busy", {e, b}, 2'b11);
      @(negedge clk); init_req = 1'b1; init_mask = 8'h01;
      @(negedge clk); e = err; init_req = 1'b0;
      check(e, "R9 bring-up refused while busy", e, 1);
      wait_done("R7 single codec list done");
      check_script(3'b010, base, "R7");

      // R7: codec 2 alone via mask 1<<2.
      foreach (base[i]) base[i] = wcnt[i];
      for (int j = 0; j < 8; j++) begin
         host_req(8'h04, 5'(j), 8'hC0 + 8'(j), e, b);
         wait_done("R8 preload write done");
         shadow[2][j] = 8'hC0 + 8'(j);
      end
      foreach (base[i]) base[i] = wcnt[i];
      @(negedge clk); init_req = 1'b1; init_mask = 8'h04;
      @(negedge clk); init_req = 1'b0;
      wait_done("R7 codec 2 list done");
      check_script(3'b100, base, "R7");

      check(bad_frames == 0, "R1 malformed frames", bad_frames, 0);
      check(hold_viol == 0, "R2 data moved while clock high", hold_viol, 0);
      check(hi_viol == 0, "R2 clock phase length", hi_viol, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R8 watchdog: actual 0x0 expected 0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule